// File: doc/BRIEF.md
# Two-Word Message FIFO Mailbox

This block is a two-way message channel between a host processor and an embedded core. Words from the host travel through an input queue to the core. Words from the core travel through an output queue back to the host. On the host side a single data register serves both directions: a write to it enqueues a word toward the core, and a read from it dequeues a word from the core. A status register reports fill flags, a sticky error bit and interrupt flags. A control register enables each queue and its interrupt. A separate mailbox word can be written from either side.

A message consists of two 32-bit words. Host software starts a send only when the input queue is empty. It writes the second word only while the status register still shows room, and each queue holds exactly one message. The core side is a show-ahead pop port and a push port with a full indication. The meaning of the messages is handled above this block.

Top module: `msg_mailbox`

## Requirements
- R1: After reset, status reads 0x00060000, control reads 0, the mailbox reads 0x0000F0F0 and `irq` is 0.
- R2: Host address 0 is data, 1 is status, 2 is control and 3 is the mailbox. In control, bit 16 enables the output queue, bit 17 the input queue, bit 24 the output interrupt and bit 25 the input interrupt. Writes to control keep only those four bits, and every other control bit reads 0.
- R3: A host write to address 0 enqueues the word into the input queue only while control bit 17 is 1. A core push enters the output queue only while control bit 16 is 1. A push that is gated off this way changes nothing and raises no error. The core receives the words in the order they were written.
- R4: Status bit 16 means the output queue is not empty, bit 17 the input queue is not full, bit 18 the output queue is not full and bit 19 the input queue is not empty. Each queue holds 2 words, so after two writes bit 17 reads 0.
- R5: A host read of address 0 dequeues the output queue in push order, with the value appearing on `host_rdata` one cycle after the read strobe. A read while the output queue is empty returns 0.
- R6: A push to a full queue or a pop from an empty queue leaves the queue unchanged and sets sticky status bit 0. Writing 1 to status bit 0 clears it.
- R7: Status bit 21 is set when a core pop empties the input queue while control bit 25 is 1. Writing 1 to status bit 21 clears it.
- R8: Status bit 22 reads 1 exactly while the output queue is non-empty and control bit 24 is 1.
- R9: A host write to address 3 loads the mailbox and clears status bit 20. A core mailbox write loads the mailbox and sets status bit 20. Writing 1 to status bit 20 also clears it.
- R10: `irq` is the OR of status bits 20, 21 and 22, registered, so it follows them one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| core_in_valid | output | 1 | Input queue holds a word |
| core_in_data | output | DW | Head word of the input queue |
| core_in_pop | input | 1 | Core removes the head word |
| core_out_full | output | 1 | Output queue is full |
| core_out_push | input | 1 | Core pushes a word |
| core_out_data | input | DW | Word pushed by the core |
| core_mbox_wr | input | 1 | Core mailbox write strobe |
| core_mbox_wdata | input | 32 | Core mailbox write data |
| irq | output | 1 | Registered interrupt request |

## Verification
The main function is exercised with a full two-word message in each direction, a third word pushed into a full queue, and a read from an empty output queue. These cases separate correct ordering and flag encoding from off-by-one depth errors and from wrong behaviour on overflow and underflow. Sequences with the queues disabled and with the interrupt enables cleared separate the gating of data from the gating of interrupts. Core and host writes to the mailbox, together with the `irq` samples around them, show that the mailbox flag is set and cleared from the correct side.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_MBOX = 2'd3
  } mbx_addr_e;

  // status bit positions (decoded by host software)
  localparam int ST_ERR = 0;
  localparam int ST_ONE = 16;
  localparam int ST_INF = 17;
  localparam int ST_ONF = 18;
  localparam int ST_INE = 19;
  localparam int ST_MBI = 20;
  localparam int ST_IFI = 21;
  localparam int ST_OFI = 22;

  // control bit positions
  localparam int CT_OEN = 16;
  localparam int CT_IEN = 17;
  localparam int CT_OIE = 24;
  localparam int CT_IIE = 25;

  localparam logic [REG_W-1:0] MBOX_RST = 32'h0000_F0F0;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_err,
  output logic          pop_err,
  output logic          drained
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push & ~full;
  assign do_pop   = pop & ~empty;
  assign push_err = push & full;
  assign pop_err  = pop & empty;
  assign drained  = do_pop & ~do_push & (count == CW'(1));
  assign head     = mem[rp];

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
  input  logic clk,
  input  logic rst,
  input  logic err_evt,
  input  logic err_clr,
  input  logic in_drained,
  input  logic in_int_en,
  input  logic ifint_clr,
  input  logic out_ne,
  input  logic out_int_en,
  input  logic mb_set,
  input  logic mb_clr,
  output logic err_q,
  output logic mbint_q,
  output logic ifint_q,
  output logic ofint,
  output logic irq
);
  assign ofint = out_ne & out_int_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      mbint_q <= 1'b0;
      ifint_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (err_evt)                     err_q   <= 1'b1;
      else if (err_clr)                err_q   <= 1'b0;
      if (mb_set)                      mbint_q <= 1'b1;
      else if (mb_clr)                 mbint_q <= 1'b0;
      if (in_drained && in_int_en)     ifint_q <= 1'b1;
      else if (ifint_clr)              ifint_q <= 1'b0;
      irq <= mbint_q | ifint_q | ofint;
    end
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          core_in_valid,
  output logic [DW-1:0] core_in_data,
  input  logic          core_in_pop,
  output logic          core_out_full,
  input  logic          core_out_push,
  input  logic [DW-1:0] core_out_data,
  input  logic          core_mbox_wr,
  input  logic [31:0]   core_mbox_wdata,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic ctl_oen, ctl_ien, ctl_oie, ctl_iie;
  logic [REG_W-1:0] mbox_q;
  logic [REG_W-1:0] stat_w, ctrl_w;

  logic wr_data, wr_stat, wr_ctrl, wr_mbox, rd_data;
  assign wr_data = host_wr & (host_addr == A_DATA);
  assign wr_stat = host_wr & (host_addr == A_STAT);
  assign wr_ctrl = host_wr & (host_addr == A_CTRL);
  assign wr_mbox = host_wr & (host_addr == A_MBOX);
  assign rd_data = host_rd & (host_addr == A_DATA);

  logic [CW-1:0] in_cnt, out_cnt;
  logic in_full, in_empty, in_perr, in_uerr, in_drained;
  logic out_full, out_empty, out_perr, out_uerr, out_drained;
  logic [DW-1:0] out_head;

  mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in_q (
    .clk(clk), .rst(rst),
    .push(wr_data & ctl_ien), .push_data(host_wdata[DW-1:0]),
    .pop(core_in_pop), .head(core_in_data), .count(in_cnt),
    .full(in_full), .empty(in_empty),
    .push_err(in_perr), .pop_err(in_uerr), .drained(in_drained)
  );

  mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out_q (
    .clk(clk), .rst(rst),
    .push(core_out_push & ctl_oen), .push_data(core_out_data),
    .pop(rd_data), .head(out_head), .count(out_cnt),
    .full(out_full), .empty(out_empty),
    .push_err(out_perr), .pop_err(out_uerr), .drained(out_drained)
  );

  assign core_in_valid = ~in_empty;
  assign core_out_full = out_full;

  logic err_q, mbint_q, ifint_q, ofint;

  mbx_flags u_flags (
    .clk(clk), .rst(rst),
    .err_evt(in_perr | in_uerr | out_perr | out_uerr),
    .err_clr(wr_stat & host_wdata[ST_ERR]),
    .in_drained(in_drained), .in_int_en(ctl_iie),
    .ifint_clr(wr_stat & host_wdata[ST_IFI]),
    .out_ne(~out_empty), .out_int_en(ctl_oie),
    .mb_set(core_mbox_wr),
    .mb_clr(wr_mbox | (wr_stat & host_wdata[ST_MBI])),
    .err_q(err_q), .mbint_q(mbint_q), .ifint_q(ifint_q),
    .ofint(ofint), .irq(irq)
  );

  always_comb begin
    stat_w         = '0;
    stat_w[ST_ERR] = err_q;
    stat_w[ST_ONE] = ~out_empty;
    stat_w[ST_INF] = ~in_full;
    stat_w[ST_ONF] = ~out_full;
    stat_w[ST_INE] = ~in_empty;
    stat_w[ST_MBI] = mbint_q;
    stat_w[ST_IFI] = ifint_q;
    stat_w[ST_OFI] = ofint;
    ctrl_w         = '0;
    ctrl_w[CT_OEN] = ctl_oen;
    ctrl_w[CT_IEN] = ctl_ien;
    ctrl_w[CT_OIE] = ctl_oie;
    ctrl_w[CT_IIE] = ctl_iie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_oen <= 1'b0;
      ctl_ien <= 1'b0;
      ctl_oie <= 1'b0;
      ctl_iie <= 1'b0;
      mbox_q  <= MBOX_RST;
    end else begin
      if (wr_ctrl) begin
        ctl_oen <= host_wdata[CT_OEN];
        ctl_ien <= host_wdata[CT_IEN];
        ctl_oie <= host_wdata[CT_OIE];
        ctl_iie <= host_wdata[CT_IIE];
      end
      if (wr_mbox)           mbox_q <= host_wdata;
      else if (core_mbox_wr) mbox_q <= core_mbox_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        A_DATA:  host_rdata <= out_empty ? '0 : 32'(out_head);
        A_STAT:  host_rdata <= stat_w;
        A_CTRL:  host_rdata <= ctrl_w;
        default: host_rdata <= mbox_q;
      endcase
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 2,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    host_addr,
  input logic          host_wr,
  input logic          host_rd,
  input logic [31:0]   host_rdata,
  input logic          core_in_pop,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt,
  input logic          ctl_ien,
  input logic          ctl_iie,
  input logic          ifint_q
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && in_cnt == CW'(DEPTH) && !core_in_pop)
    |=> (in_cnt == CW'(DEPTH))); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd0 && out_cnt == '0) |=> (host_rdata == '0)); // R5

  AST_GATED_PUSH: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && !ctl_ien && !core_in_pop) |=> $stable(in_cnt)); // R3

  AST_DRAIN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (core_in_pop && in_cnt == CW'(1) && ctl_iie && !(host_wr && host_addr == 2'd0))
    |=> ifint_q); // R7
endmodule

bind msg_mailbox mbx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .core_in_pop(core_in_pop),
  .in_cnt(in_cnt), .out_cnt(out_cnt), .ctl_ien(ctl_ien),
  .ctl_iie(ctl_iie), .ifint_q(ifint_q)
);

// File: tb/msg_mailbox_bench.sv
module msg_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        core_in_valid, core_in_pop = 1'b0;
  logic [31:0] core_in_data;
  logic        core_out_full, core_out_push = 1'b0;
  logic [31:0] core_out_data = '0;
  logic        core_mbox_wr = 1'b0;
  logic [31:0] core_mbox_wdata = '0;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msg_mailbox u_msg_mailbox (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_in_valid(core_in_valid), .core_in_data(core_in_data),
    .core_in_pop(core_in_pop), .core_out_full(core_out_full),
    .core_out_push(core_out_push), .core_out_data(core_out_data),
    .core_mbox_wr(core_mbox_wr), .core_mbox_wdata(core_mbox_wdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 host write, 1 host read check, 2 core pop check, 3 core push
    logic [1:0]  addr;
    logic [31:0] val;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd2, 32'h0303_0000, 8'd2},  // enable all (R2)
    '{2'd1, 2'd1, 32'h0006_0000, 8'd4},  // both empty (R4)
    '{2'd0, 2'd0, 32'h0000_00A1, 8'd3},
    '{2'd1, 2'd1, 32'h000E_0000, 8'd4},  // one word in (R4)
    '{2'd0, 2'd0, 32'h0000_00B2, 8'd3},
    '{2'd1, 2'd1, 32'h000C_0000, 8'd4},  // input full (R4)
    '{2'd0, 2'd0, 32'h0000_00C3, 8'd6},  // overflow (R6)
    '{2'd1, 2'd1, 32'h000C_0001, 8'd6},
    '{2'd0, 2'd1, 32'h0000_0001, 8'd6},  // clear error
    '{2'd1, 2'd1, 32'h000C_0000, 8'd6},
    '{2'd2, 2'd0, 32'h0000_00A1, 8'd3},  // order (R3)
    '{2'd2, 2'd0, 32'h0000_00B2, 8'd3},
    '{2'd1, 2'd1, 32'h0026_0000, 8'd7},  // drained flag (R7)
    '{2'd0, 2'd1, 32'h0020_0000, 8'd7},
    '{2'd1, 2'd1, 32'h0006_0000, 8'd7},
    '{2'd3, 2'd0, 32'h0000_0011, 8'd3},
    '{2'd3, 2'd0, 32'h0000_0022, 8'd3},
    '{2'd1, 2'd1, 32'h0043_0000, 8'd8},  // out full + level flag (R8)
    '{2'd1, 2'd0, 32'h0000_0011, 8'd5},  // read order (R5)
    '{2'd1, 2'd0, 32'h0000_0022, 8'd5},
    '{2'd1, 2'd0, 32'h0000_0000, 8'd5},  // empty read returns 0
    '{2'd1, 2'd1, 32'h0006_0001, 8'd6}   // underflow error (R6)
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic cpush(input logic [31:0] d);
    core_out_data = d; core_out_push = 1'b1;
    @(negedge clk); core_out_push = 1'b0;
  endtask

  task automatic cpop(output logic [31:0] d);
    d = core_in_data; core_in_pop = 1'b1;
    @(negedge clk); core_in_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R1 reset state
    hread(2'd1, r); check("R1 status", r, 32'h0006_0000);
    hread(2'd2, r); check("R1 control", r, 32'h0);
    hread(2'd3, r); check("R1 mailbox", r, 32'h0000_F0F0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R2 control writable bits only
    hwrite(2'd2, 32'hFFFF_FFFF);
    hread(2'd2, r); check("R2 control mask", r, 32'h0303_0000);

    do_reset();
    foreach (VEC[i]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: hwrite(VEC[i].addr, VEC[i].val);
        2'd1: begin hread(VEC[i].addr, r); check(tag, r, VEC[i].val); end
        2'd2: begin
          check(tag, {31'b0, core_in_valid}, 32'h1);
          cpop(r); check(tag, r, VEC[i].val);
        end
        default: cpush(VEC[i].val);
      endcase
    end

    // R3 gated input and output queues: no entry, no error
    do_reset();
    hwrite(2'd0, 32'h55);
    cpush(32'h66);
    hread(2'd1, r); check("R3 gated pushes", r, 32'h0006_0000);
    check("R3 core_in_valid", {31'b0, core_in_valid}, 32'h0);
    // R6 core pop on empty
    cpop(r);
    hread(2'd1, r); check("R6 core underflow", r, 32'h0006_0001);
    // R9 core mailbox write
    core_mbox_wdata = 32'hABCD; core_mbox_wr = 1'b1;
    @(negedge clk); core_mbox_wr = 1'b0;
    hread(2'd3, r); check("R9 core mailbox value", r, 32'hABCD);
    check("R10 irq high", {31'b0, irq}, 32'h1);
    hread(2'd1, r); check("R9 mailbox flag", r, 32'h0016_0001);
    hwrite(2'd3, 32'h77);
    hread(2'd1, r); check("R9 host write clears", r, 32'h0006_0001);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    hread(2'd3, r); check("R9 host mailbox value", r, 32'h77);
    // R7 and R8 with interrupt enables off
    hwrite(2'd2, 32'h0003_0000);
    hwrite(2'd0, 32'h99);
    cpop(r); check("R3 enabled word", r, 32'h99);
    cpush(32'h5A);
    hread(2'd1, r); check("R7 R8 no flags when disabled", r, 32'h0007_0001);
    @(negedge clk);
    check("R10 irq quiet", {31'b0, irq}, 32'h0);
    // R8 enabling later raises the level flag
    hwrite(2'd2, 32'h0103_0000);
    hread(2'd1, r); check("R8 level on enable", r, 32'h0047_0001);
    hread(2'd0, r); check("R5 read word", r, 32'h5A);
    hread(2'd1, r); check("R8 level drops", r, 32'h0006_0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule